// File: doc/BRIEF.md
# Radix page table walker

A sequential translation engine that turns a 64-bit effective address into a real address. It walks a multi-level radix page table held in memory. A request is accepted on a valid/ready port. The walker first reads a process table entry, located from a table base pin and the request's process identifier. From that entry it takes the tree size, the root directory base and the root index width. It then runs a segment-range check and a tree-configuration check. After that it fetches one directory entry per level until it reaches a leaf. At the leaf it applies the permission and reference/change rules and forms the real address.

Memory reads use a request channel with valid/ready and a response channel with a single valid strobe. The walker keeps `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. After each accepted read it waits for exactly one `mem_rsp_valid` pulse, so it never has more than one read outstanding. The memory side may stall the request channel for any number of cycles, and it may answer after any latency. A request on the front port is taken only while `req_ready` is high, which happens only when the walker is idle. The result is announced by a one-cycle `done` pulse. The result pins then hold their values until the next request is accepted.

Bit positions below use LSB0 numbering (bit 63 is the most significant).

Top module: `radix_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle, and a request is taken when `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle per walk, and `req_ready` is high again in the following cycle.
- R2: The first read goes to the process table entry. Its address is built as follows. Bits 63..56 are zero. Bits 55..36 come from `prtbl_base`. Bits 35..12 come from `prtbl_base[35:12]`, except that the low N of those positions take the effective PID bits 31..8, where N = `prtbl_base[4:0]` (at most 24). Bits 11..4 are the effective PID bits 7..0. Bits 3..0 are zero. The effective PID is 0 when `req_addr[63]` is 1, and `req_pid` otherwise.
- R3: The process table entry is decoded as follows. The 6-bit tree size is {0, entry[7:5], entry[62:61]}. The root index width is {0, entry[4:0]}. The root base is entry[55:8], with bits 7..0 taken as zero.
- R4: A segment error ends the walk after the process table read. It is raised when `req_addr[63]` differs from `req_addr[62]`, or when any bit k of `req_addr`, with 31+S <= k <= 61, is set. Here S is the tree size.
- R5: A bad-tree error ends the walk when the root index width is below 5, above 16, or above S+19. Otherwise the working shift becomes S+19 minus the root index width.
- R6: Each directory entry address is built from the current base with its bits 18..3 replaced, in the low W positions, by (`req_addr` >> (12+shift)) masked to W bits. W is the current index width. Bits 63..56 and 2..0 are zero.
- R7: A fetched directory entry with bit 63 (valid) clear ends the walk with a no-entry error.
- R8: Take a valid entry with bit 62 (leaf) clear. Its next-level width entry[4:0] must be at least 5, at most 16 and at most the current shift. The entry must also not be the fourth entry fetched. If either condition fails, the walk ends with a bad-tree error. Otherwise the shift drops by that width and the next base is entry[55:8] with bits 7..0 taken as zero.
- R9: At a leaf, permission is granted only when `req_priv` is 1 or leaf bit 3 is 0. For a data access, permission also needs bit1 OR (bit2 AND NOT `req_store`). For a fetch (`req_iside`=1), it needs bit0 AND NOT bit5.
- R10: The reference/change check at a leaf passes when bit8 AND (bit7 OR NOT `req_store`). When permission fails, only `err_perm` is raised. `err_rc` is raised only when permission passes and this check fails.
- R11: A leaf with no error gives `phys_addr` as follows. Bits 63..56 are zero. Bits 11..0 are leaf bits 11..0. In bits 55..12, the low `shift` positions come from `req_addr` and the rest from the leaf.
- R12: `mem_req_valid` and `mem_req_addr` stay unchanged while `mem_req_ready` is low, and no new read is issued before the response to the previous one.
- R13: At most one error flag is set. `phys_addr` is zero whenever an error flag is set. All result pins hold their values from one `done` until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prtbl_base | input | 64 | Process table base (bits 55..12) and size (bits 4..0), sampled at request |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 64 | Effective address |
| req_pid | input | 32 | Process identifier |
| req_priv | input | 1 | Privileged access |
| req_iside | input | 1 | Instruction fetch (1) or data access (0) |
| req_store | input | 1 | Data access is a store |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Doubleword address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle end-of-walk strobe |
| phys_addr | output | 64 | Real address, zero on error |
| err_seg | output | 1 | Segment error |
| err_badtree | output | 1 | Bad tree configuration |
| err_nopte | output | 1 | Invalid directory entry |
| err_perm | output | 1 | Permission error |
| err_rc | output | 1 | Reference/change error |

## Verification
Some properties are checked on every cycle: the one-cycle `done` strobe, the idle-only `req_ready`, a stalled read request holding steady, the single outstanding read, exclusive error flags with a zeroed address, and result pins holding between walks. The bench's scenarios are needed for the rest, because only they fix the table contents. These are the exact read address sequence, the tree and segment decisions at their boundaries, fault detection at each level, the permission/reference ordering, and the merging of address bits for large pages.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;
  typedef enum logic [2:0] {
    WS_IDLE, WS_PRT_REQ, WS_PRT_WAIT, WS_SEG, WS_PDE_REQ, WS_PDE_WAIT, WS_DONE
  } walk_state_e;

  typedef struct packed {
    logic seg;
    logic badtree;
    logic nopte;
    logic perm;
    logic rc;
  } walk_err_t;

  // ones in the n least significant positions
  function automatic logic [63:0] low_ones(input logic [6:0] n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/rw_seg_check.sv
module rw_seg_check #(
  parameter int MIN_IDX_BITS = 5,
  parameter int MAX_IDX_BITS = 16
) (
  input  logic [63:0] va,
  input  logic [6:0]  shift,
  input  logic [5:0]  mbits,
  output logic        seg_err,
  output logic        bad_err,
  output logic [6:0]  next_shift
);
  import radix_walker_pkg::*;
  logic [63:0] fm;
  logic [7:0]  limit;
  assign fm    = low_ones(shift);
  assign limit = {1'b0, shift} + 8'd19;
  assign seg_err = (va[63] != va[62]) || (|(va[61:31] & ~fm[30:0]));
  assign bad_err = (int'(mbits) < MIN_IDX_BITS) || (int'(mbits) > MAX_IDX_BITS) ||
                   ({2'b00, mbits} > limit);
  assign next_shift = shift + 7'd19 - {1'b0, mbits};
endmodule

// File: rtl/rw_addr_gen.sv
module rw_addr_gen (
  input  logic [63:0] prtbl,
  input  logic [63:0] va,
  input  logic [31:0] pid,
  input  logic [63:0] pgbase,
  input  logic [6:0]  shift,
  input  logic [5:0]  mbits,
  output logic [63:0] prte_addr,
  output logic [63:0] pde_addr
);
  import radix_walker_pkg::*;
  logic [31:0] pid_eff;
  logic [63:0] fm_p, fm_i;
  logic [51:0] va_sh;
  logic [15:0] idx;
  assign pid_eff = va[63] ? 32'd0 : pid;
  assign fm_p    = low_ones({2'b00, prtbl[4:0]});
  assign fm_i    = low_ones({1'b0, mbits});
  assign va_sh   = va[63:12] >> shift;
  assign idx     = va_sh[15:0];
  assign prte_addr = {8'h00, prtbl[55:36],
                      (prtbl[35:12] & ~fm_p[23:0]) | (pid_eff[31:8] & fm_p[23:0]),
                      pid_eff[7:0], 4'h0};
  assign pde_addr  = {8'h00, pgbase[55:19],
                      (pgbase[18:3] & ~fm_i[15:0]) | (idx & fm_i[15:0]), 3'b000};
endmodule

// File: rtl/rw_leaf_eval.sv
module rw_leaf_eval (
  input  logic [63:0] pte,
  input  logic [63:0] va,
  input  logic [6:0]  shift,
  input  logic        priv,
  input  logic        iside,
  input  logic        store,
  output logic        perm_err,
  output logic        rc_err,
  output logic [63:0] pa
);
  import radix_walker_pkg::*;
  logic        perm_ok, rc_ok, side_ok;
  logic [63:0] fm;
  assign fm      = low_ones(shift);
  assign side_ok = iside ? (pte[0] & ~pte[5]) : (pte[1] | (pte[2] & ~store));
  assign perm_ok = (priv | ~pte[3]) & side_ok;
  assign rc_ok   = pte[8] & (pte[7] | ~store);
  assign perm_err = ~perm_ok;
  assign rc_err   = perm_ok & ~rc_ok;
  assign pa = {8'h00, (pte[55:12] & ~fm[43:0]) | (va[55:12] & fm[43:0]), pte[11:0]};
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int MAX_LEVELS   = 4,
  parameter int MIN_IDX_BITS = 5,
  parameter int MAX_IDX_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] prtbl_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  input  logic [31:0] req_pid,
  input  logic        req_priv,
  input  logic        req_iside,
  input  logic        req_store,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [63:0] phys_addr,
  output logic        err_seg,
  output logic        err_badtree,
  output logic        err_nopte,
  output logic        err_perm,
  output logic        err_rc
);
  import radix_walker_pkg::*;
  localparam int LVL_W = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

  walk_state_e      st;
  logic [63:0]      va_q, prt_q, base_q, pa_q;
  logic [31:0]      pid_q;
  logic             priv_q, iside_q, store_q;
  logic [6:0]       shift_q;
  logic [5:0]       mbits_q;
  logic [LVL_W-1:0] lvl_q;
  walk_err_t        err_q;

  logic [63:0] prte_addr, pde_addr, leaf_pa;
  logic        seg_err, root_bad, perm_err, rc_err, nl_bad;
  logic [6:0]  seg_shift;
  logic [5:0]  nl_bits;

  rw_addr_gen u_addr (
    .prtbl(prt_q), .va(va_q), .pid(pid_q), .pgbase(base_q), .shift(shift_q),
    .mbits(mbits_q), .prte_addr(prte_addr), .pde_addr(pde_addr)
  );

  rw_seg_check #(.MIN_IDX_BITS(MIN_IDX_BITS), .MAX_IDX_BITS(MAX_IDX_BITS)) u_seg (
    .va(va_q), .shift(shift_q), .mbits(mbits_q), .seg_err(seg_err),
    .bad_err(root_bad), .next_shift(seg_shift)
  );

  rw_leaf_eval u_leaf (
    .pte(mem_rsp_data), .va(va_q), .shift(shift_q), .priv(priv_q), .iside(iside_q),
    .store(store_q), .perm_err(perm_err), .rc_err(rc_err), .pa(leaf_pa)
  );

  assign nl_bits = {1'b0, mem_rsp_data[4:0]};
  assign nl_bad  = (int'(nl_bits) < MIN_IDX_BITS) || (int'(nl_bits) > MAX_IDX_BITS) ||
                   ({1'b0, nl_bits} > shift_q) || (lvl_q == LAST_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WS_IDLE;
      va_q    <= '0;
      prt_q   <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      pid_q   <= '0;
      priv_q  <= 1'b0;
      iside_q <= 1'b0;
      store_q <= 1'b0;
      shift_q <= '0;
      mbits_q <= '0;
      lvl_q   <= '0;
      err_q   <= '0;
    end else begin
      unique case (st)
        WS_IDLE: if (req_valid) begin
          va_q    <= req_addr;
          prt_q   <= prtbl_base;
          pid_q   <= req_pid;
          priv_q  <= req_priv;
          iside_q <= req_iside;
          store_q <= req_store;
          err_q   <= '0;
          pa_q    <= '0;
          st      <= WS_PRT_REQ;
        end
        WS_PRT_REQ: if (mem_req_ready) st <= WS_PRT_WAIT;
        WS_PRT_WAIT: if (mem_rsp_valid) begin
          shift_q <= {1'b0, 1'b0, mem_rsp_data[7:5], mem_rsp_data[62:61]};
          mbits_q <= {1'b0, mem_rsp_data[4:0]};
          base_q  <= {8'h00, mem_rsp_data[55:8], 8'h00};
          st      <= WS_SEG;
        end
        WS_SEG: begin
          if (seg_err) begin
            err_q.seg <= 1'b1;
            st        <= WS_DONE;
          end else if (root_bad) begin
            err_q.badtree <= 1'b1;
            st            <= WS_DONE;
          end else begin
            shift_q <= seg_shift;
            lvl_q   <= '0;
            st      <= WS_PDE_REQ;
          end
        end
        WS_PDE_REQ: if (mem_req_ready) st <= WS_PDE_WAIT;
        WS_PDE_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[63]) begin
            err_q.nopte <= 1'b1;
            st          <= WS_DONE;
          end else if (mem_rsp_data[62]) begin
            err_q.perm <= perm_err;
            err_q.rc   <= rc_err;
            if (!perm_err && !rc_err) pa_q <= leaf_pa;
            st <= WS_DONE;
          end else if (nl_bad) begin
            err_q.badtree <= 1'b1;
            st            <= WS_DONE;
          end else begin
            mbits_q <= nl_bits;
            shift_q <= shift_q - {1'b0, nl_bits};
            base_q  <= {8'h00, mem_rsp_data[55:8], 8'h00};
            lvl_q   <= lvl_q + 1'b1;
            st      <= WS_PDE_REQ;
          end
        end
        WS_DONE: st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_PRT_REQ) || (st == WS_PDE_REQ);
  assign mem_req_addr  = (st == WS_PRT_REQ) ? prte_addr : pde_addr;
  assign done          = (st == WS_DONE);
  assign phys_addr     = pa_q;
  assign err_seg       = err_q.seg;
  assign err_badtree   = err_q.badtree;
  assign err_nopte     = err_q.nopte;
  assign err_perm      = err_q.perm;
  assign err_rc        = err_q.rc;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic [63:0] phys_addr,
  input logic        err_seg,
  input logic        err_badtree,
  input logic        err_nopte,
  input logic        err_perm,
  input logic        err_rc
);
  logic [4:0] errs;
  logic       in_flight;
  assign errs = {err_seg, err_badtree, err_nopte, err_perm, err_rc};

  always_ff @(posedge clk) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid) in_flight <= 1'b0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R1
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done); // R1
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !in_flight); // R12
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000 && mem_req_addr[63:56] == 8'h00); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(errs) <= 1); // R13
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (errs != 5'b0) |-> phys_addr == 64'd0); // R13
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> done || ($stable(phys_addr) && $stable(errs))); // R13
endmodule

bind radix_walker radix_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .phys_addr(phys_addr), .err_seg(err_seg), .err_badtree(err_badtree),
  .err_nopte(err_nopte), .err_perm(err_perm), .err_rc(err_rc)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] prtbl_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [31:0] req_pid = '0;
  logic        req_priv = 1'b0, req_iside = 1'b0, req_store = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [63:0] phys_addr;
  logic        err_seg, err_badtree, err_nopte, err_perm, err_rc;

  radix_walker u_dut (.*);

  always #5 clk = ~clk;

  // leaf / entry encodings (LSB0), see R7..R10
  localparam logic [63:0] B_V   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] B_L   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] B_R   = 64'h100;
  localparam logic [63:0] B_C   = 64'h080;
  localparam logic [63:0] B_CI  = 64'h020;
  localparam logic [63:0] B_PRV = 64'h008;
  localparam logic [63:0] B_RD  = 64'h004;
  localparam logic [63:0] B_RW  = 64'h002;
  localparam logic [63:0] B_EX  = 64'h001;
  localparam logic [63:0] ROOT  = 64'h0000_0000_0100_0000;
  localparam logic [63:0] TBLS  = 64'h0000_0000_0200_0000;

  int errors = 0, checks = 0, cycles = 0;
  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] exp_q[$];
  logic        bp_mode = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;
  logic        in_flight = 1'b0;
  int          rsp_timer = 0;
  logic [63:0] rsp_hold = '0;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem_img.exists(a) ? mem_img[a] : 64'd0;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: process table entry address
  function automatic logic [63:0] prte_of(input logic [63:0] va, input logic [31:0] pid,
                                          input logic [63:0] prt);
    logic [63:0] ep, hi, m;
    int sz;
    ep = va[63] ? 64'd0 : {32'd0, pid};
    sz = int'(prt & 64'd31);
    if (sz > 24) sz = 24;
    m  = (64'd1 << sz) - 64'd1;
    hi = (prt >> 12) & 64'h0000_0FFF_FFFF_FFFF;
    hi = (hi & ~m) | ((ep >> 8) & m);
    return (hi << 12) | ((ep & 64'hFF) << 4);
  endfunction

  function automatic logic [63:0] idx_of(input logic [63:0] va, input int sh, input int w);
    logic [63:0] x;
    if (sh < 0) sh = 0;
    x = (12 + sh >= 64) ? 64'd0 : (va >> (12 + sh));
    return x & ((64'd1 << w) - 64'd1);
  endfunction

  // Builds a tree: sizes sz0..sz3 per level, nf entries fetched, last one = last_e
  task automatic build(input logic [63:0] va, input logic [31:0] pid, input int rts,
                       input int sz0, input int sz1, input int sz2, input int sz3,
                       input int nf, input logic [63:0] last_e);
    int sz[4];
    int sh;
    logic [63:0] base, nb, ea, e;
    sz[0] = sz0; sz[1] = sz1; sz[2] = sz2; sz[3] = sz3;
    mem_img.delete();
    e = (64'(rts & 3) << 61) | (64'((rts >> 2) & 7) << 5) | ROOT | 64'(sz0);
    mem_img[prte_of(va, pid, prtbl_base)] = e;
    sh = rts + 19 - sz0;
    base = ROOT;
    for (int k = 0; k < nf; k++) begin
      ea = base | (idx_of(va, sh, sz[k]) << 3);
      if (k == nf - 1) mem_img[ea] = last_e;
      else begin
        nb = TBLS + 64'(k + 1) * 64'h10_0000;
        mem_img[ea] = B_V | nb | 64'(sz[(k + 1) % 4]);
        sh = sh - sz[(k + 1) % 4];
        base = nb;
      end
    end
  endtask

  // Behavioural reference: expected reads, error vector {seg,bad,nopte,perm,rc}, address
  task automatic ref_walk(input logic [63:0] va, input logic [31:0] pid, input logic priv,
                          input logic iside, input logic st, output logic [4:0] eerr,
                          output logic [63:0] epa);
    logic [63:0] a, d, base, pa;
    int rts, w, sh, nl;
    logic ok_p, ok_rc;
    eerr = '0; epa = '0;
    exp_q.delete();
    a = prte_of(va, pid, prtbl_base);
    exp_q.push_back(a);
    d = rd(a);
    rts = int'(((d >> 5) & 64'd7) << 2) | int'((d >> 61) & 64'd3);   // R3
    w = int'(d & 64'd31);
    base = d & 64'h00FF_FFFF_FFFF_FF00;
    if (va[63] != va[62]) begin eerr = 5'b10000; return; end        // R4
    for (int b = 31; b <= 61; b++)
      if (va[b] && (b >= 31 + rts)) begin eerr = 5'b10000; return; end
    if (w < 5 || w > 16 || w > rts + 19) begin eerr = 5'b01000; return; end  // R5
    sh = rts + 19 - w;
    for (int lv = 0; lv < 8; lv++) begin
      a = (base & ~(((64'd1 << w) - 64'd1) << 3)) | (idx_of(va, sh, w) << 3);  // R6
      exp_q.push_back(a);
      d = rd(a);
      if (!d[63]) begin eerr = 5'b00100; return; end                 // R7
      if (d[62]) begin
        ok_p = (priv || !d[3]) && (iside ? (d[0] && !d[5]) : (d[1] || (d[2] && !st)));  // R9
        ok_rc = d[8] && (d[7] || !st);                                // R10
        if (!ok_p) begin eerr = 5'b00010; return; end
        if (!ok_rc) begin eerr = 5'b00001; return; end
        pa = d & 64'h00FF_FFFF_FFFF_FFFF;                             // R11
        for (int i = 0; i < 44; i++) if (i < sh) pa[12 + i] = va[12 + i];
        epa = pa;
        return;
      end
      nl = int'(d & 64'd31);
      if (lv == 3 || nl < 5 || nl > 16 || nl > sh) begin eerr = 5'b01000; return; end  // R8
      sh = sh - nl; w = nl;
      base = d & 64'h00FF_FFFF_FFFF_FF00;
    end
  endtask

  // memory model: request acceptance, address comparison, delayed response (R12)
  initial begin
    forever begin
      @(negedge clk);
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      mem_rsp_valid = 1'b0;
      if (in_flight) begin
        mem_req_ready = 1'b0;
        if (rsp_timer == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_hold;
          in_flight     = 1'b0;
        end else rsp_timer--;
      end else if (mem_req_valid) begin
        if (bp_mode && lcg[17]) mem_req_ready = 1'b0;
        else begin
          mem_req_ready = 1'b1;
          if (exp_q.size() == 0) check("R6 unexpected read", 1'b0, mem_req_addr, 64'd0);
          else begin
            logic [63:0] ex;
            ex = exp_q.pop_front();
            check("R6 read address", mem_req_addr == ex, mem_req_addr, ex);
          end
          rsp_hold  = rd(mem_req_addr);
          rsp_timer = bp_mode ? int'(lcg[21:20]) : 0;
          in_flight = 1'b1;
        end
      end else mem_req_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input string tag, input logic [63:0] va, input logic [31:0] pid,
                     input logic priv, input logic iside, input logic st);
    logic [4:0]  eerr, aerr;
    logic [63:0] epa;
    logic        busy_ok;
    int          n;
    ref_walk(va, pid, priv, iside, st, eerr, epa);
    @(negedge clk);
    check({tag, " R1 ready idle"}, req_ready == 1'b1, 64'(req_ready), 64'd1);
    req_addr = va; req_pid = pid; req_priv = priv; req_iside = iside; req_store = st;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1; n = 0;
    while (!done && n < 300) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk); n++;
    end
    check({tag, " R1 busy not ready"}, busy_ok && done, 64'(done), 64'd1);
    aerr = {err_seg, err_badtree, err_nopte, err_perm, err_rc};
    check({tag, " flags"}, aerr == eerr, 64'(aerr), 64'(eerr));
    check({tag, " R11 phys_addr"}, phys_addr == epa, phys_addr, epa);
    check({tag, " R6 all reads issued"}, exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    check({tag, " R1 done one cycle"}, !done && req_ready, 64'({done, req_ready}), 64'b01);
    check({tag, " R13 result held"}, phys_addr == epa &&
          {err_seg, err_badtree, err_nopte, err_perm, err_rc} == eerr, phys_addr, epa);
  endtask

  localparam logic [63:0] VA4K = 64'h000A_BCDE_F123_4567;
  localparam logic [63:0] LEAF_OK = B_V | B_L | 64'h0000_0077_7777_7000 | B_R | B_C | B_RW | B_RD;

  initial begin
    prtbl_base = 64'h0000_0000_0040_0002;   // base 0x400000, two PID bits merged
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", req_ready === 1'b1, 64'(req_ready), 64'd1);
    check("R13 reset outputs", !done && !mem_req_valid && phys_addr == 64'd0 &&
          {err_seg, err_badtree, err_nopte, err_perm, err_rc} == 5'd0, phys_addr, 64'd0);

    // 4-level 4K walk, data load (R2 R3 R6 R11)
    build(VA4K, 32'h0000_0345, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R11 4k load", VA4K, 32'h0000_0345, 1'b0, 1'b0, 1'b0);
    // large page at third fetch, address bits merged (R11)
    build(VA4K, 32'h0000_0345, 21, 13, 9, 9, 9, 3, LEAF_OK | 64'h1F_F000);
    run("R11 large page", VA4K, 32'h0000_0345, 1'b0, 1'b0, 1'b0);
    // top quadrant: effective PID zero (R2)
    build(64'hC000_0000_0000_5000, 32'h0000_0FFF, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R2 quadrant pid zero", 64'hC000_0000_0000_5000, 32'h0000_0FFF, 1'b1, 1'b0, 1'b0);
    // segment errors and boundary (R4)
    build(64'h4000_0000_0000_0000, 32'd1, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R4 quadrant mismatch", 64'h4000_0000_0000_0000, 32'd1, 1'b0, 1'b0, 1'b0);
    build(64'h0010_0000_0000_0000, 32'd1, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R4 bit above tree", 64'h0010_0000_0000_0000, 32'd1, 1'b0, 1'b0, 1'b0);
    build(64'h0008_0000_0000_0000, 32'd1, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R4 top bit inside tree", 64'h0008_0000_0000_0000, 32'd1, 1'b0, 1'b0, 1'b0);
    // root size bounds (R5)
    build(VA4K, 32'd2, 21, 4, 9, 9, 9, 4, LEAF_OK);
    run("R5 root size 4", VA4K, 32'd2, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd2, 21, 17, 9, 9, 9, 4, LEAF_OK);
    run("R5 root size 17", VA4K, 32'd2, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd2, 21, 16, 9, 9, 6, 4, LEAF_OK);
    run("R5 root size 16", VA4K, 32'd2, 1'b0, 1'b0, 1'b0);
    // invalid entry (R7)
    build(VA4K, 32'd3, 21, 13, 9, 9, 9, 2, LEAF_OK & ~B_V);
    run("R7 invalid entry", VA4K, 32'd3, 1'b0, 1'b0, 1'b0);
    // tree faults (R8)
    build(VA4K, 32'd3, 21, 13, 9, 9, 9, 4, B_V | TBLS | 64'd5);
    run("R8 fourth nonleaf", VA4K, 32'd3, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd3, 21, 13, 4, 9, 9, 4, LEAF_OK);
    run("R8 next size 4", VA4K, 32'd3, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd3, 21, 13, 9, 16, 5, 4, LEAF_OK);
    run("R8 size over shift", VA4K, 32'd3, 1'b0, 1'b0, 1'b0);
    // reference/change and precedence (R10)
    build(VA4K, 32'd4, 21, 13, 9, 9, 9, 4, LEAF_OK & ~B_C);
    run("R10 store no change", VA4K, 32'd4, 1'b0, 1'b0, 1'b1);
    run("R10 load no change ok", VA4K, 32'd4, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd4, 21, 13, 9, 9, 9, 4, (LEAF_OK & ~B_C & ~B_RW));
    run("R10 perm precedes rc", VA4K, 32'd4, 1'b0, 1'b0, 1'b1);
    build(VA4K, 32'd4, 21, 13, 9, 9, 9, 4, LEAF_OK & ~B_R);
    run("R10 load no reference", VA4K, 32'd4, 1'b0, 1'b0, 1'b0);
    // permission rules (R9)
    build(VA4K, 32'd5, 21, 13, 9, 9, 9, 4, LEAF_OK | B_EX);
    run("R9 fetch exec", VA4K, 32'd5, 1'b0, 1'b1, 1'b0);
    build(VA4K, 32'd5, 21, 13, 9, 9, 9, 4, LEAF_OK | B_EX | B_CI);
    run("R9 fetch inhibited", VA4K, 32'd5, 1'b0, 1'b1, 1'b0);
    build(VA4K, 32'd5, 21, 13, 9, 9, 9, 4, LEAF_OK);
    run("R9 fetch no exec", VA4K, 32'd5, 1'b0, 1'b1, 1'b0);
    build(VA4K, 32'd5, 21, 13, 9, 9, 9, 4, LEAF_OK | B_PRV);
    run("R9 priv page user", VA4K, 32'd5, 1'b0, 1'b0, 1'b0);
    run("R9 priv page priv", VA4K, 32'd5, 1'b1, 1'b0, 1'b0);
    build(VA4K, 32'd5, 21, 13, 9, 9, 9, 4, (LEAF_OK & ~B_RW));
    run("R9 read-only store", VA4K, 32'd5, 1'b0, 1'b0, 1'b1);
    // memory stalls and latency (R12)
    bp_mode = 1'b1;
    build(VA4K, 32'h0000_0345, 21, 13, 9, 9, 9, 4, LEAF_OK);
    for (int i = 0; i < 4; i++)
      run("R12 stalled memory", VA4K, 32'h0000_0345, 1'b0, 1'b0, 1'b0);
    build(VA4K, 32'd6, 21, 13, 9, 9, 9, 3, LEAF_OK | 64'h0A_5000);
    run("R12 stalled large page", VA4K, 32'd6, 1'b0, 1'b0, 1'b1);
    bp_mode = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule